// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block times the sample and convert phases of a successive-approximation converter from one control word. The core clock is divided into an ADC clock enable. When an accepted trigger arrives, the block raises a sample strobe for a programmed number of ADC clocks. It then raises a convert strobe for a fixed nineteen ADC clocks and ends with a one-cycle ready pulse. The analog converter, the result path and the bus logic sit outside the block. The bus side writes the control word through a plain load port and reads it back.

The block has six trigger sources: an external start pin, two timer pulses, a PWM sync pulse, a one-shot software request and free-running software conversion. The pin, timer and PWM inputs are synchronised to the core clock, and only their rising edges count. The one-shot request clears its own source field once its conversion is done. Triggers are honoured only while conversion is enabled, the converter is powered and the power-up settling time has passed.

Control word layout (bit positions): [2:0] trigger source, [5:3] clock divide code, [7:6] acquisition code, [9:8] input mode, [10] power on, [11] conversion enable.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, the control word reads 12'h088: divide code 001, acquisition code 10 and all other fields 0. The sample, convert, busy and ready outputs are low.
- R2: Divide codes 000 to 101 give an ADC clock of the core clock divided by 1, 2, 4, 8, 16 or 32. Codes 110 and 111 also give divide-by-32.
- R3: Acquisition codes 00, 01, 10 and 11 hold the sample strobe for 2, 4, 8 or 16 ADC clocks. Acquisition always begins on an ADC clock.
- R4: The convert strobe follows the sample strobe and lasts 19 ADC clocks. The ready pulse is high for one core cycle, in the first cycle after the convert strobe falls. Busy is high while either strobe is high.
- R5: Source codes: 000 external pin, 001 timer-1, 010 timer-0, 101 PWM sync. For these codes only a rising edge on the selected input starts a conversion. Edges on the other inputs do nothing. Codes 110 and 111 start no conversion.
- R6: Source code 011 starts exactly one conversion. After that conversion the source field reads 000.
- R7: Source code 100 restarts acquisition on the first ADC clock after each ready pulse. Ready pulses are then spaced (acquisition clocks + 20) ADC clocks apart.
- R8: While the enable bit is 0, no trigger starts a conversion.
- R9: While the power bit is 0, the block is idle and any running conversion is aborted with no ready pulse. After the power bit is set, no conversion starts for CORE_MHZ*SETTLE_US core cycles (200 by default).
- R10: A trigger that arrives while a conversion is running is ignored, and it does not start a conversion afterwards.
- R11: The input-mode field appears unchanged on the mode output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load the control word |
| cfgWrData | input | 12 | Control word to load |
| extStartIn | input | 1 | External start pin (asynchronous) |
| timer1In | input | 1 | Timer-1 trigger (asynchronous) |
| timer0In | input | 1 | Timer-0 trigger (asynchronous) |
| pwmSyncIn | input | 1 | PWM sync trigger (asynchronous) |
| cfgRdData | output | 12 | Current control word |
| inModeOut | output | 2 | Input mode for the converter |
| sampleOut | output | 1 | Sample/acquire strobe |
| convertOut | output | 1 | Convert phase strobe |
| busyOut | output | 1 | Sample or convert in progress |
| readyOut | output | 1 | One-cycle result-ready pulse |

## Verification
The bench measures the sample and convert widths in core cycles for several combinations of divide code and acquisition code, including the /1 and /32 extremes and a reserved divide code. A wrong width points to the divider or to the phase counter. Each edge-triggered source is fired on its own input and then shown to ignore the other inputs, which exposes a swapped trigger selector. The bench also checks the one-shot clear, the spacing of free-running conversions, triggers sent during a conversion, triggers sent before settling, and a power-down in the middle of acquisition. These cases separate the gating rules from the timing paths.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W = 12;

  localparam logic [2:0] SRC_EXT    = 3'd0;
  localparam logic [2:0] SRC_TMR1   = 3'd1;
  localparam logic [2:0] SRC_TMR0   = 3'd2;
  localparam logic [2:0] SRC_SINGLE = 3'd3;
  localparam logic [2:0] SRC_CONT   = 3'd4;
  localparam logic [2:0] SRC_PWM    = 3'd5;

  localparam int TRG_EXT  = 0;
  localparam int TRG_TMR1 = 1;
  localparam int TRG_TMR0 = 2;
  localparam int TRG_PWM  = 3;
  localparam int TRG_N    = 4;

  typedef struct packed {
    logic       convEn;
    logic       powerOn;
    logic [1:0] inMode;
    logic [1:0] acqSel;
    logic [2:0] clkDiv;
    logic [2:0] srcSel;
  } seqCfg_t;

  localparam seqCfg_t CFG_RESET = '{convEn: 1'b0, powerOn: 1'b0, inMode: 2'b00,
                                    acqSel: 2'b10, clkDiv: 3'b001, srcSel: SRC_EXT};

  typedef struct packed {
    logic loadAcq;
    logic loadConv;
    logic countDown;
    logic clrSrc;
  } seqStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_ACQ, ST_CONV} seqState_t;
endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CORE_MHZ  = 40,
  parameter int SETTLE_US = 5,
  parameter int CONV_CLKS = 19,
  parameter int MAX_DIV_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [TRG_N-1:0] trigIn,
  input  seqStrobe_t       strobe,
  output seqCfg_t          cfgQ,
  output logic             adcTick,
  output logic             settled,
  output logic             cntZero,
  output logic [TRG_N-1:0] trigRise
);
  localparam int PHASE_MAX  = (CONV_CLKS > 16) ? CONV_CLKS : 16;
  localparam int PHASE_W    = $clog2(PHASE_MAX);
  localparam int DIV_CW     = (MAX_DIV_LOG2 > 0) ? MAX_DIV_LOG2 : 1;
  localparam int SETTLE_CYC = CORE_MHZ * SETTLE_US;
  localparam int SET_W      = $clog2(SETTLE_CYC + 1);

  // control word register; a host write wins over the one-shot clear
  always_ff @(posedge clk) begin
    if (!rstN)              cfgQ <= CFG_RESET;
    else if (cfgWrEn)       cfgQ <= seqCfg_t'(cfgWrData);
    else if (strobe.clrSrc) cfgQ.srcSel <= SRC_EXT;
  end

  // ADC clock enable from a free-running prescaler
  logic [2:0]        divLog;
  logic [DIV_CW-1:0] ratioM1;
  logic [DIV_CW-1:0] divCnt;

  always_comb begin
    divLog  = (int'(cfgQ.clkDiv) > MAX_DIV_LOG2) ? 3'(MAX_DIV_LOG2) : cfgQ.clkDiv;
    ratioM1 = (DIV_CW'(1) << divLog) - DIV_CW'(1);
    adcTick = (divCnt >= ratioM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        divCnt <= '0;
    else if (adcTick) divCnt <= '0;
    else              divCnt <= divCnt + DIV_CW'(1);
  end

  // power-up settling counter, core clocks
  logic [SET_W-1:0] settleCnt;
  assign settled = (settleCnt == SET_W'(SETTLE_CYC));

  always_ff @(posedge clk) begin
    if (!rstN || !cfgQ.powerOn) settleCnt <= '0;
    else if (!settled)          settleCnt <= settleCnt + SET_W'(1);
  end

  // phase counter shared by acquisition and conversion
  logic [PHASE_W-1:0] phaseCnt;
  logic [PHASE_W-1:0] acqLoad;
  assign acqLoad = (PHASE_W'(2) << cfgQ.acqSel) - PHASE_W'(1);
  assign cntZero = (phaseCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.loadAcq)   phaseCnt <= acqLoad;
    else if (strobe.loadConv)  phaseCnt <= PHASE_W'(CONV_CLKS - 1);
    else if (strobe.countDown) phaseCnt <= phaseCnt - PHASE_W'(1);
  end

  // two-flop synchronisers with rising-edge detect
  for (genvar i = 0; i < TRG_N; i++) begin : g_sync
    logic [2:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[1:0], trigIn[i]};
    end
    assign trigRise[i] = chain[1] & ~chain[2];
  end

  p_src_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrSrc && !cfgWrEn) |=> (cfgQ.srcSel == SRC_EXT));

  p_settle_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.powerOn |=> !settled);

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (adcTick && cfgQ.clkDiv != 3'd0 && !cfgWrEn) |=> !adcTick);
endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqCfg_t          cfg,
  input  logic             adcTick,
  input  logic             settled,
  input  logic             cntZero,
  input  logic [TRG_N-1:0] trigRise,
  output seqStrobe_t       strobe,
  output logic             sampleOut,
  output logic             convertOut,
  output logic             busyOut,
  output logic             readyOut
);
  seqState_t stateQ, stateD;
  logic      armed, trigHit, lastClk, readyD;

  assign armed   = cfg.convEn && cfg.powerOn && settled;
  assign lastClk = adcTick && cntZero;

  always_comb begin
    case (cfg.srcSel)
      SRC_EXT:    trigHit = trigRise[TRG_EXT];
      SRC_TMR1:   trigHit = trigRise[TRG_TMR1];
      SRC_TMR0:   trigHit = trigRise[TRG_TMR0];
      SRC_SINGLE: trigHit = 1'b1;
      SRC_CONT:   trigHit = 1'b1;
      SRC_PWM:    trigHit = trigRise[TRG_PWM];
      default:    trigHit = 1'b0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    readyD = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (armed && trigHit) stateD = ST_ARM;
      ST_ARM: if (adcTick) begin
        stateD         = ST_ACQ;
        strobe.loadAcq = 1'b1;
      end
      ST_ACQ: if (lastClk) begin
        stateD          = ST_CONV;
        strobe.loadConv = 1'b1;
      end else if (adcTick) begin
        strobe.countDown = 1'b1;
      end
      ST_CONV: if (lastClk) begin
        readyD        = 1'b1;
        strobe.clrSrc = (cfg.srcSel == SRC_SINGLE);
        stateD        = (cfg.srcSel == SRC_CONT && armed) ? ST_ARM : ST_IDLE;
      end else if (adcTick) begin
        strobe.countDown = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
    if (!cfg.powerOn) begin
      stateD = ST_IDLE;
      strobe = '0;
      readyD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      readyOut <= 1'b0;
    end else begin
      stateQ   <= stateD;
      readyOut <= readyD;
    end
  end

  assign sampleOut  = (stateQ == ST_ACQ);
  assign convertOut = (stateQ == ST_CONV);
  assign busyOut    = sampleOut | convertOut;

  p_ready_after_conv_r4: assert property (@(posedge clk) disable iff (!rstN)
    readyOut |-> ($past(stateQ) == ST_CONV && stateQ != ST_CONV));

  p_power_off_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.powerOn |=> (stateQ == ST_IDLE && !readyOut));

  p_arm_needs_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ARM && $past(stateQ) == ST_IDLE) |-> $past(cfg.convEn));

  p_acq_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACQ && $past(stateQ) == ST_ARM) |-> $past(adcTick));
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CORE_MHZ  = 40,
  parameter int SETTLE_US = 5,
  parameter int CONV_CLKS = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             extStartIn,
  input  logic             timer1In,
  input  logic             timer0In,
  input  logic             pwmSyncIn,
  output logic [CFG_W-1:0] cfgRdData,
  output logic [1:0]       inModeOut,
  output logic             sampleOut,
  output logic             convertOut,
  output logic             busyOut,
  output logic             readyOut
);
  seqCfg_t          cfg;
  seqStrobe_t       strobe;
  logic             adcTick, settled, cntZero;
  logic [TRG_N-1:0] trigIn, trigRise;

  assign trigIn    = {pwmSyncIn, timer0In, timer1In, extStartIn};
  assign cfgRdData = cfg;
  assign inModeOut = cfg.inMode;

  adc_seq_datapath #(
    .CORE_MHZ (CORE_MHZ),
    .SETTLE_US(SETTLE_US),
    .CONV_CLKS(CONV_CLKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .trigIn   (trigIn),
    .strobe   (strobe),
    .cfgQ     (cfg),
    .adcTick  (adcTick),
    .settled  (settled),
    .cntZero  (cntZero),
    .trigRise (trigRise)
  );

  adc_seq_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .adcTick   (adcTick),
    .settled   (settled),
    .cntZero   (cntZero),
    .trigRise  (trigRise),
    .strobe    (strobe),
    .sampleOut (sampleOut),
    .convertOut(convertOut),
    .busyOut   (busyOut),
    .readyOut  (readyOut)
  );
endmodule

// File: tb/adc_conv_sequencer_test.sv
`timescale 1ns/1ps
module adc_conv_sequencer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [11:0] cfgWrData = '0;
  logic        extStartIn = 1'b0, timer1In = 1'b0, timer0In = 1'b0, pwmSyncIn = 1'b0;
  logic [11:0] cfgRdData;
  logic [1:0]  inModeOut;
  logic        sampleOut, convertOut, busyOut, readyOut;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  adc_conv_sequencer uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .extStartIn(extStartIn), .timer1In(timer1In), .timer0In(timer0In),
    .pwmSyncIn(pwmSyncIn), .cfgRdData(cfgRdData), .inModeOut(inModeOut),
    .sampleOut(sampleOut), .convertOut(convertOut), .busyOut(busyOut),
    .readyOut(readyOut)
  );

  function automatic logic [11:0] mk(input bit en, input bit pwr, input logic [1:0] mode,
                                     input logic [1:0] acq, input logic [2:0] dv,
                                     input logic [2:0] src);
    return {en, pwr, mode, acq, dv, src};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: extStartIn = 1'b1; 1: timer1In = 1'b1; 2: timer0In = 1'b1; default: pwmSyncIn = 1'b1;
    endcase
    repeat (3) @(negedge clk);
    extStartIn = 1'b0; timer1In = 1'b0; timer0In = 1'b0; pwmSyncIn = 1'b0;
  endtask

  // watch for any conversion activity over a window
  task automatic expectIdle(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busyOut || readyOut) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  // wait for one conversion and measure its phases in core cycles
  task automatic measure(input int expAcq, input int expConv, input string req);
    int n = 0, a = 0, c = 0;
    while (!sampleOut && n < 5000) begin @(negedge clk); n++; end
    check(sampleOut, {req, " start"}, n, 0);
    while (sampleOut) begin a++; @(negedge clk); end
    check(a == expAcq, {req, " sample width"}, a, expAcq);
    check(busyOut == convertOut, {req, " busy"}, busyOut, convertOut);
    while (convertOut) begin c++; @(negedge clk); end
    check(c == expConv, {req, " convert width"}, c, expConv);
    check(readyOut, {req, " ready"}, readyOut, 1);
    @(negedge clk);
    check(!readyOut, {req, " ready width"}, readyOut, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cfgRdData == 12'h088, "R1 reset word", cfgRdData, 12'h088);
    check({sampleOut, convertOut, busyOut, readyOut} == 4'b0, "R1 outputs", busyOut, 0);
  endtask

  task automatic t_settle;
    wr(mk(1, 1, 2'b00, 2'b00, 3'd0, 3'd0));
    repeat (20) @(negedge clk);
    pulse(0);
    expectIdle(60, "R9 settle gate");
    repeat (200) @(negedge clk);
    pulse(0);
    measure(2, 19, "R9 R5 R2 R3 ext div1 acq2");
  endtask

  task automatic t_widths;
    wr(mk(1, 1, 2'b00, 2'b10, 3'd1, 3'd1)); pulse(1);
    measure(16, 38, "R2 R3 R5 tmr1 div2 acq8");
    wr(mk(1, 1, 2'b00, 2'b11, 3'd2, 3'd2)); pulse(2);
    measure(64, 76, "R2 R3 R5 tmr0 div4 acq16");
    wr(mk(1, 1, 2'b00, 2'b01, 3'd5, 3'd5)); pulse(3);
    measure(128, 608, "R2 R3 R5 pwm div32 acq4");
    wr(mk(1, 1, 2'b00, 2'b00, 3'd7, 3'd0)); pulse(0);
    measure(64, 608, "R2 reserved divide code");
    wr(mk(1, 1, 2'b00, 2'b01, 3'd3, 3'd0)); pulse(0);
    measure(32, 152, "R2 R4 div8 acq4");
  endtask

  task automatic t_wrong_src;
    wr(mk(1, 1, 2'b00, 2'b00, 3'd0, 3'd1));
    pulse(0); pulse(2); pulse(3);
    expectIdle(40, "R5 unselected inputs");
    wr(mk(1, 1, 2'b00, 2'b00, 3'd0, 3'd6));
    pulse(0); pulse(1); pulse(2); pulse(3);
    expectIdle(40, "R5 reserved source 110");
    wr(mk(1, 1, 2'b00, 2'b00, 3'd0, 3'd7));
    pulse(0);
    expectIdle(40, "R5 reserved source 111");
  endtask

  task automatic t_disable;
    wr(mk(0, 1, 2'b00, 2'b00, 3'd0, 3'd0));
    pulse(0);
    expectIdle(40, "R8 disabled pin trigger");
    wr(mk(0, 1, 2'b00, 2'b00, 3'd0, 3'd4));
    expectIdle(60, "R8 disabled continuous");
  endtask

  task automatic t_single;
    wr(mk(1, 1, 2'b00, 2'b00, 3'd0, 3'd3));
    measure(2, 19, "R6 one-shot");
    check(cfgRdData[2:0] == 3'd0, "R6 source cleared", cfgRdData[2:0], 0);
    expectIdle(100, "R6 no second conversion");
  endtask

  task automatic t_continuous;
    int n = 1;
    wr(mk(1, 1, 2'b00, 2'b01, 3'd1, 3'd4));
    measure(8, 38, "R7 continuous first");
    while (!readyOut && n < 1000) begin @(negedge clk); n++; end
    check(n == 48, "R7 ready spacing", n, 48);
    wr(mk(1, 1, 2'b00, 2'b01, 3'd1, 3'd0));
    n = 0;
    while (busyOut && n < 1000) begin @(negedge clk); n++; end
    expectIdle(100, "R7 stops after leaving continuous");
  endtask

  task automatic t_busy_ignore;
    wr(mk(1, 1, 2'b00, 2'b00, 3'd1, 3'd0));
    pulse(0);
    while (!convertOut) @(negedge clk);
    pulse(0);
    while (!readyOut) @(negedge clk);
    expectIdle(200, "R10 trigger during conversion");
    check(!sampleOut, "R10 sample after window", sampleOut, 0);
  endtask

  task automatic t_mode;
    wr(mk(1, 1, 2'b10, 2'b00, 3'd1, 3'd0));
    check(inModeOut == 2'b10, "R11 mode 10", inModeOut, 2);
    wr(mk(1, 1, 2'b01, 2'b00, 3'd1, 3'd0));
    check(inModeOut == 2'b01, "R11 mode 01", inModeOut, 1);
  endtask

  task automatic t_power_abort;
    int rdy = 0;
    wr(mk(1, 1, 2'b00, 2'b11, 3'd1, 3'd0));
    pulse(0);
    while (!sampleOut) @(negedge clk);
    wr(mk(1, 0, 2'b00, 2'b11, 3'd1, 3'd0));
    @(negedge clk);
    check(!busyOut, "R9 power-down abort", busyOut, 0);
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (readyOut || busyOut) rdy++; end
    check(rdy == 0, "R9 no ready after abort", rdy, 0);
    wr(mk(1, 1, 2'b00, 2'b11, 3'd1, 3'd0));
    pulse(0);
    expectIdle(50, "R9 settle after repower");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_settle();
    t_widths();
    t_wrong_src();
    t_disable();
    t_single();
    t_continuous();
    t_busy_ignore();
    t_mode();
    t_power_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule